// File: doc/BRIEF.md
# Fault Powerdown Controller

This block drives the power-enable lines of a set of converter channels and of one shared bias supply. Each enable normally follows a user power request. A two-bit policy selects whether detected faults force a channel off, and which faults count. Each channel has a fault flag and a mask bit. The bias supply has its own fault flag, and a bias fault takes down the bias and every channel with it.

When a fault forces a powerdown, the block keeps a per-supply trip flag. A recovery-mode bit chooses how the trip is released. In automatic mode the trip clears once the fault is gone. In manual mode the trip also needs a one-cycle re-arm strobe, which stands in for a software re-enable write. A strobe that arrives while the fault is still present does nothing.

The block is used between a fault monitor and the analog power switches. The fault detection, the analog sequencing and the register access all stay outside it.

Top module: `fault_pd_ctrl`

## Requirements
- R1: With `pd_mode` at 0 (no fault powerdown) or 3 (reserved, treated as 0), faults have no effect. One clock after such a mode is sampled, every trip is released, so `ch_en` equals `ch_req` and `bias_en` equals `bias_req`.
- R2: With `pd_mode` at 1, a channel whose `ch_fault` bit is 1 and whose `ch_mask` bit is 0 is switched off at the next clock edge. A fault whose mask bit is 1 leaves its channel on.
- R3: With `pd_mode` at 2, a channel whose `ch_fault` bit is 1 is switched off at the next clock edge, whatever its mask bit holds.
- R4: With `pd_mode` at 1 or 2, `bias_fault` at 1 switches off `bias_en` and every bit of `ch_en` at the next clock edge.
- R5: With `manual_rcv` at 0, a tripped channel is re-enabled at the clock edge after its counting fault is sampled clear, provided its request is still set.
- R6: With `manual_rcv` at 1, a tripped channel stays off after its fault clears. It is released at the clock edge where its bit of `ch_rearm` is sampled at 1.
- R7: A re-arm strobe that is sampled while the counting fault is still present has no effect, and the supply stays off.
- R8: The bias trip follows the same automatic and manual recovery rules, using `bias_rearm`. Releasing it restores the bias and every channel whose own trip is clear.
- R9: An enable is never 1 while its request is 0. A request change reaches its enable in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears every trip |
| pd_mode | input | 2 | Fault powerdown policy: 0 none, 1 unmasked faults, 2 all faults, 3 reserved (as 0) |
| manual_rcv | input | 1 | 0 automatic recovery, 1 recovery only by re-arm strobe |
| ch_req | input | NUM_CH | Per-channel user power request |
| ch_fault | input | NUM_CH | Per-channel live fault flag |
| ch_mask | input | NUM_CH | Per-channel fault mask (1 = masked) |
| ch_rearm | input | NUM_CH | Per-channel manual re-enable strobe |
| bias_req | input | 1 | Bias supply power request |
| bias_fault | input | 1 | Bias supply live fault flag |
| bias_rearm | input | 1 | Bias manual re-enable strobe |
| ch_en | output | NUM_CH | Per-channel power enable |
| bias_en | output | 1 | Bias supply power enable |

## Verification
Faults, mode changes and strobes act through one register stage. They show up on the enables one clock edge after they are sampled. Requests act with no register at all, so they show up in the same cycle. The bench drives every input just after a falling edge and samples the outputs at the next falling edge. That places exactly one rising edge between stimulus and check, which suits both kinds of path. For the recovery cases, a check is made both before and after the releasing event, so a recovery that comes one edge early or one edge late is caught.

// File: rtl/fault_pd_pkg.sv
// Package: fault_pd_pkg
// Shared policy encoding and the fault qualification function for the
// fault powerdown controller. Assumes a two-bit policy field.
package fault_pd_pkg;

    typedef enum logic [1:0] {
        PD_NONE     = 2'd0,
        PD_UNMASKED = 2'd1,
        PD_ANY      = 2'd2,
        PD_RSVD     = 2'd3
    } pd_mode_e;

    // True when the policy lets faults force a powerdown.
    function automatic logic policy_active(input pd_mode_e m);
        return (m == PD_UNMASKED) || (m == PD_ANY);
    endfunction

endpackage

// File: rtl/fault_qualify.sv
// Module: fault_qualify
// Decides, per channel and for the bias, whether a live fault counts under
// the present policy. Purely combinational. Assumes fault and mask bits are
// already synchronous to clk.
module fault_qualify
    import fault_pd_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [1:0]        mode_raw,
    input  logic [NUM_CH-1:0] ch_fault,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic              bias_fault,
    output logic              active,
    output logic [NUM_CH-1:0] ch_hit,
    output logic              bias_hit
);

    pd_mode_e mode;

    // Map the raw field onto the policy type and flag whether faults act.
    always_comb begin
        mode   = pd_mode_e'(mode_raw);
        active = policy_active(mode);
    end

    // Choose which channel faults count: unmasked only, or all of them.
    always_comb begin
        unique case (mode)
            PD_UNMASKED: ch_hit = ch_fault & ~ch_mask;
            PD_ANY:      ch_hit = ch_fault;
            default:     ch_hit = '0;
        endcase
    end

    // The bias fault counts under either active policy.
    always_comb begin
        bias_hit = active & bias_fault;
    end

endmodule

// File: rtl/trip_cell.sv
// Module: trip_cell
// One trip flag. It is set when a counting fault is seen and released
// either by itself once the fault is gone (automatic) or by a re-arm strobe
// once the fault is gone (manual). An inactive policy clears it. Assumes the
// strobe is a one-cycle pulse synchronous to clk.
module trip_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hit,
    input  logic manual,
    input  logic rearm,
    output logic tripped
);

    logic trip_d;

    // Next-state rule: an inactive policy releases, a live hit sets, else recovery applies.
    always_comb begin
        if (!active) begin
            trip_d = 1'b0;
        end else if (hit) begin
            trip_d = 1'b1;
        end else if (tripped) begin
            trip_d = manual ? ~rearm : 1'b0;
        end else begin
            trip_d = 1'b0;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tripped <= 1'b0;
        end else begin
            tripped <= trip_d;
        end
    end

endmodule

// File: rtl/fault_pd_ctrl.sv
// Module: fault_pd_ctrl
// Top level of the fault powerdown controller. Qualifies the faults, keeps
// one trip flag per channel plus one for the bias supply, and gates the
// user requests with them. A bias trip holds every channel off. Assumes all
// inputs are synchronous to clk.
module fault_pd_ctrl #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pd_mode,
    input  logic              manual_rcv,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_fault,
    input  logic [NUM_CH-1:0] ch_mask,
    input  logic [NUM_CH-1:0] ch_rearm,
    input  logic              bias_req,
    input  logic              bias_fault,
    input  logic              bias_rearm,
    output logic [NUM_CH-1:0] ch_en,
    output logic              bias_en
);

    logic              active;
    logic [NUM_CH-1:0] ch_hit;
    logic              bias_hit;
    logic [NUM_CH-1:0] ch_trip;
    logic              bias_trip;

    fault_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .mode_raw   (pd_mode),
        .ch_fault   (ch_fault),
        .ch_mask    (ch_mask),
        .bias_fault (bias_fault),
        .active     (active),
        .ch_hit     (ch_hit),
        .bias_hit   (bias_hit)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        trip_cell u_trip (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (active),
            .hit     (ch_hit[i]),
            .manual  (manual_rcv),
            .rearm   (ch_rearm[i]),
            .tripped (ch_trip[i])
        );
    end

    trip_cell u_bias_trip (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .hit     (bias_hit),
        .manual  (manual_rcv),
        .rearm   (bias_rearm),
        .tripped (bias_trip)
    );

    // Gate the requests with the trip flags; a bias trip holds every channel off.
    always_comb begin
        ch_en   = ch_req & ~ch_trip & {NUM_CH{~bias_trip}};
        bias_en = bias_req & ~bias_trip;
    end

endmodule

// File: rtl/fault_pd_ctrl_chk.sv
// Module: fault_pd_ctrl_chk
// Property checker for fault_pd_ctrl, attached to it by bind. It observes
// the ports and the trip flags.
module fault_pd_ctrl_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pd_mode,
    input logic              manual_rcv,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_fault,
    input logic [NUM_CH-1:0] ch_mask,
    input logic [NUM_CH-1:0] ch_rearm,
    input logic              bias_req,
    input logic              bias_fault,
    input logic [NUM_CH-1:0] ch_en,
    input logic              bias_en,
    input logic [NUM_CH-1:0] ch_trip
);

    logic act;

    // Policy is active only for the unmasked and all-fault encodings.
    always_comb begin
        act = (pd_mode == 2'd1) || (pd_mode == 2'd2);
    end

    // R1: an inactive policy releases every trip by the next cycle.
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (ch_en == ch_req) && (bias_en == bias_req));

    // R2: unmasked faults under policy 1 turn their channels off.
    assert_unmasked_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode == 2'd1) |=> ((ch_en & $past(ch_fault & ~ch_mask)) == '0));

    // R3: any fault under policy 2 turns its channel off.
    assert_any_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode == 2'd2) |=> ((ch_en & $past(ch_fault)) == '0));

    // R4: a bias fault takes down the bias and every channel.
    assert_bias_cascade_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act && bias_fault) |=> (!bias_en && (ch_en == '0)));

    // R6: in manual recovery a trip without a strobe persists.
    assert_manual_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && manual_rcv) |=> (($past(ch_trip & ~ch_rearm) & ~ch_trip) == '0));

    // R9: an enable never exceeds its request.
    assert_en_within_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_en & ~ch_req) == '0) && !(bias_en && !bias_req));

endmodule

bind fault_pd_ctrl fault_pd_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_mode    (pd_mode),
    .manual_rcv (manual_rcv),
    .ch_req     (ch_req),
    .ch_fault   (ch_fault),
    .ch_mask    (ch_mask),
    .ch_rearm   (ch_rearm),
    .bias_req   (bias_req),
    .bias_fault (bias_fault),
    .ch_en      (ch_en),
    .bias_en    (bias_en),
    .ch_trip    (ch_trip)
);

// File: tb/tb_fault_pd_ctrl.sv
// Directed bench for fault_pd_ctrl: one task per scenario.
module tb_fault_pd_ctrl;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   pd_mode;
    logic         manual_rcv;
    logic [N-1:0] ch_req, ch_fault, ch_mask, ch_rearm;
    logic         bias_req, bias_fault, bias_rearm;
    logic [N-1:0] ch_en;
    logic         bias_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_pd_ctrl #(.NUM_CH(N)) dut (
        .clk(clk), .rst_n(rst_n), .pd_mode(pd_mode), .manual_rcv(manual_rcv),
        .ch_req(ch_req), .ch_fault(ch_fault), .ch_mask(ch_mask),
        .ch_rearm(ch_rearm), .bias_req(bias_req), .bias_fault(bias_fault),
        .bias_rearm(bias_rearm), .ch_en(ch_en), .bias_en(bias_en)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [N-1:0] exp_ch, input logic exp_b);
        n_chk++;
        if (ch_en !== exp_ch || bias_en !== exp_b) begin
            n_fail++;
            $display("FAIL %s: ch_en=%b bias_en=%b expected ch_en=%b bias_en=%b",
                     req, ch_en, bias_en, exp_ch, exp_b);
        end
    endtask

    task automatic quiet();
        ch_fault = '0; ch_mask = '0; ch_rearm = '0;
        bias_fault = 1'b0; bias_rearm = 1'b0;
        pd_mode = 2'd0; manual_rcv = 1'b0;
        ch_req = '1; bias_req = 1'b1;
        tick(); tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pd_mode = 2'd2; manual_rcv = 1'b0;
        ch_req = '0; ch_fault = '0; ch_mask = '0; ch_rearm = '0;
        bias_req = 1'b0; bias_fault = 1'b0; bias_rearm = 1'b0;
        tick(); tick();
        check("R9 reset", 4'b0000, 1'b0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_idle_modes();
        quiet();
        ch_fault = '1; bias_fault = 1'b1; pd_mode = 2'd0;
        tick();
        check("R1 mode0 ignores faults", 4'b1111, 1'b1);
        pd_mode = 2'd3;
        tick();
        check("R1 mode3 ignores faults", 4'b1111, 1'b1);
    endtask

    task automatic t_unmasked();
        quiet();
        pd_mode = 2'd1; ch_fault = 4'b0011; ch_mask = 4'b0001;
        tick();
        check("R2 unmasked only", 4'b1101, 1'b1);
        ch_fault = '0;
        tick();
        check("R5 auto recovery", 4'b1111, 1'b1);
    endtask

    task automatic t_any();
        quiet();
        pd_mode = 2'd2; ch_fault = 4'b0011; ch_mask = 4'b0001;
        tick();
        check("R3 any fault", 4'b1100, 1'b1);
        ch_fault = '0;
        tick();
        check("R5 auto recovery mode2", 4'b1111, 1'b1);
    endtask

    task automatic t_bias_auto();
        quiet();
        pd_mode = 2'd1; bias_fault = 1'b1;
        tick();
        check("R4 bias cascade", 4'b0000, 1'b0);
        bias_fault = 1'b0;
        tick();
        check("R8 bias auto recovery", 4'b1111, 1'b1);
    endtask

    task automatic t_manual_ch();
        quiet();
        manual_rcv = 1'b1; pd_mode = 2'd2; ch_fault = 4'b0100;
        tick();
        check("R3 manual trip", 4'b1011, 1'b1);
        ch_rearm = 4'b0100;
        tick();
        ch_rearm = '0;
        check("R7 strobe during fault", 4'b1011, 1'b1);
        ch_fault = '0;
        tick();
        check("R6 held after clear", 4'b1011, 1'b1);
        tick();
        check("R6 still held", 4'b1011, 1'b1);
        ch_rearm = 4'b0100;
        tick();
        ch_rearm = '0;
        check("R6 strobe releases", 4'b1111, 1'b1);
    endtask

    task automatic t_manual_bias();
        quiet();
        manual_rcv = 1'b1; pd_mode = 2'd1; bias_fault = 1'b1;
        tick();
        check("R4 bias cascade manual", 4'b0000, 1'b0);
        bias_fault = 1'b0;
        tick();
        check("R8 bias held", 4'b0000, 1'b0);
        bias_rearm = 1'b1;
        tick();
        bias_rearm = 1'b0;
        check("R8 bias strobe releases", 4'b1111, 1'b1);
    endtask

    task automatic t_request_gate();
        quiet();
        ch_req = 4'b0101; bias_req = 1'b0;
        tick();
        check("R9 request gates", 4'b0101, 1'b0);
        pd_mode = 2'd2; ch_fault = 4'b0001;
        tick();
        check("R9 trip and request", 4'b0100, 1'b0);
        ch_fault = '0; ch_req = 4'b0000;
        tick();
        check("R5 no request after recovery", 4'b0000, 1'b0);
    endtask

    task automatic t_mode_release();
        quiet();
        manual_rcv = 1'b1; pd_mode = 2'd2; ch_fault = 4'b0010;
        tick();
        check("R3 trip before release", 4'b1101, 1'b1);
        ch_fault = '0; pd_mode = 2'd0;
        tick();
        check("R1 idle mode releases trip", 4'b1111, 1'b1);
    endtask

    initial begin
        t_reset();
        t_idle_modes();
        t_unmasked();
        t_any();
        t_bias_auto();
        t_manual_ch();
        t_manual_bias();
        t_request_gate();
        t_mode_release();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule